// File: doc/BRIEF.md
# DMA Request Router

This block links peripheral request lines to DMA channels. Each request line has its own small map register. The register holds an enable flag and the number of the channel that the line serves. The router registers every request input once. It then folds the mapped lines into one request level per channel. When a channel's level rises or falls, it emits a one-cycle event toward that channel's status logic: "request asserted" on the rising edge and "end of receive" on the falling edge.

Software programs the map registers through a simple register port. Reads are combinational and writes take effect at the clock edge. The registers sit in two separate address windows. The low window holds the first 64 registers and the high window holds the rest. A write that names a channel the block does not have is refused and flagged. Channel arbitration and the data movement itself are handled elsewhere.

Top module: `dma_req_router`

## Requirements
- R1: A map register reads back as a 32-bit word with the enable flag in bit 7 and the channel number in bits 4:0. Bits 6:5 and bits 31:8 always read as zero, whatever value was written to them.
- R2: Register n (n below 64) is at byte address 0x100 + 4n. Register n from 64 to NUM_REQ-1 is at 0x1100 + 4(n-64). Any other address, including one that is not word aligned, reads zero, and a write to it changes no register and raises no error.
- R3: A request input sampled high at a clock edge, after being sampled low at the edge before, whose register is enabled, drives `ch_level` of its channel high. It also pulses `ch_assert_evt` of that channel for exactly one cycle. Both outputs change right after that edge.
- R4: While a channel's level stays high, `ch_assert_evt` does not pulse again for that channel.
- R5: When a channel's level falls, `ch_eor_evt` of that channel pulses for one cycle and `ch_level` goes low. Both outputs change right after the edge at which the fall is sampled.
- R6: A request whose map register has the enable flag clear has no effect on any channel level or event.
- R7: When several enabled requests map to one channel, that channel's level is their OR. Events fire only when the OR changes.
- R8: A write with bit 7 set and a channel number at or above NUM_CH is not stored. `cfg_err` is high for the one cycle after that write's clock edge. A write with bit 7 clear is stored with any channel number and raises no error.
- R9: After reset, every map register reads zero and all channel levels, events and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | NUM_REQ | Peripheral request lines, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| cfg_err | output | 1 | Pulse marking a refused write (invalid channel) |
| ch_level | output | NUM_CH | Current request level of each channel |
| ch_assert_evt | output | NUM_CH | One-cycle pulse when a channel's level rises |
| ch_eor_evt | output | NUM_CH | One-cycle pulse when a channel's level falls |

## Verification
The bench probes the edges of both address windows: the last low register, the first and last high registers, the word just past the high window, and an unaligned address. A decoder with an off-by-one would alias or drop registers there. It maps two requests onto one channel and overlaps them in time. A router that edge-detected each line on its own would emit a second assert event or an early end-of-receive event. It writes an out-of-range channel, an in-range top channel, and a disabled entry that holds a large channel number. A range check placed on the wrong side or ignoring the enable flag would store a bad entry or flag a harmless one.

// File: rtl/dma_rt_pkg.sv
package dma_rt_pkg;
  localparam int BUS_AW     = 16;
  localparam int BUS_DW     = 32;
  localparam int CH_FIELD_W = 5;
  localparam int IDX_W      = 7;
  localparam int LO_COUNT   = 64;
  localparam logic [BUS_AW-1:0] LO_BASE = 16'h0100;
  localparam logic [BUS_AW-1:0] HI_BASE = 16'h1100;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } map_sel_t;

  // Translate a byte address into a map-register index across both windows.
  function automatic map_sel_t decode_map_addr(input logic [BUS_AW-1:0] addr,
                                               input int num_req);
    map_sel_t s;
    int       n;
    s = '0;
    n = -1;
    if (addr[1:0] == 2'b00) begin
      if (addr >= LO_BASE && addr < LO_BASE + BUS_AW'(4 * LO_COUNT))
        n = int'(addr[BUS_AW-1:2] - LO_BASE[BUS_AW-1:2]);
      else if (addr >= HI_BASE)
        n = int'(addr[BUS_AW-1:2] - HI_BASE[BUS_AW-1:2]) + LO_COUNT;
    end
    if (n >= 0 && n < num_req) begin
      s.hit = 1'b1;
      s.idx = IDX_W'(n);
    end
    return s;
  endfunction

  function automatic logic [BUS_DW-1:0] pack_map(input logic vld,
                                                 input logic [CH_FIELD_W-1:0] ch);
    return {{(BUS_DW-8){1'b0}}, vld, 2'b00, ch};
  endfunction

  function automatic logic chan_out_of_range(input logic [BUS_DW-1:0] wd,
                                             input int num_ch);
    return wd[7] && (int'(wd[CH_FIELD_W-1:0]) >= num_ch);
  endfunction
endpackage

// File: rtl/rt_map_regs.sv
module rt_map_regs
  import dma_rt_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   bus_wr,
  input  logic [BUS_AW-1:0]                      bus_addr,
  input  logic [BUS_DW-1:0]                      bus_wdata,
  output logic [BUS_DW-1:0]                      bus_rdata,
  output logic [NUM_REQ-1:0]                     map_vld,
  output logic [NUM_REQ-1:0][CH_FIELD_W-1:0]     map_ch,
  output logic                                   wr_bad,
  output logic                                   cfg_err
);
  map_sel_t sel;
  logic     wr_ok;

  always_comb begin
    sel    = decode_map_addr(bus_addr, NUM_REQ);
    wr_bad = bus_wr && sel.hit && chan_out_of_range(bus_wdata, NUM_CH);
    wr_ok  = bus_wr && sel.hit && !chan_out_of_range(bus_wdata, NUM_CH);
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_vld[r] <= 1'b0;
        map_ch[r]  <= '0;
      end else if (wr_ok && sel.idx == IDX_W'(r)) begin
        map_vld[r] <= bus_wdata[7];
        map_ch[r]  <= bus_wdata[CH_FIELD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= wr_bad;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel.hit)
      bus_rdata = pack_map(map_vld[sel.idx], map_ch[sel.idx]);
  end
endmodule

// File: rtl/rt_req_fold.sv
module rt_req_fold
  import dma_rt_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REQ-1:0]                 req_in,
  input  logic [NUM_REQ-1:0]                 map_vld,
  input  logic [NUM_REQ-1:0][CH_FIELD_W-1:0] map_ch,
  output logic [NUM_CH-1:0]                  level
);
  logic [NUM_REQ-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_in;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_REQ-1:0] hits;
    always_comb begin
      for (int r = 0; r < NUM_REQ; r++)
        hits[r] = req_q[r] && map_vld[r] && (map_ch[r] == CH_FIELD_W'(c));
    end
    assign level[c] = |hits;
  end
endmodule

// File: rtl/rt_edge_det.sv
module rt_edge_det #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rt_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic               bus_wr,
  input  logic [15:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cfg_err,
  output logic [NUM_CH-1:0]  ch_level,
  output logic [NUM_CH-1:0]  ch_assert_evt,
  output logic [NUM_CH-1:0]  ch_eor_evt
);
  logic [NUM_REQ-1:0]                 map_vld;
  logic [NUM_REQ-1:0][CH_FIELD_W-1:0] map_ch;
  logic                               wr_bad;

  rt_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .map_vld(map_vld),
    .map_ch(map_ch), .wr_bad(wr_bad), .cfg_err(cfg_err)
  );

  rt_req_fold #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_fold (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .map_vld(map_vld),
    .map_ch(map_ch), .level(ch_level)
  );

  rt_edge_det #(.WIDTH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(ch_level),
    .rise(ch_assert_evt), .fall(ch_eor_evt)
  );
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import dma_rt_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_CH-1:0]                  ch_level,
  input logic [NUM_CH-1:0]                  ch_assert_evt,
  input logic [NUM_CH-1:0]                  ch_eor_evt,
  input logic                               cfg_err,
  input logic                               wr_bad,
  input logic [NUM_REQ-1:0]                 map_vld,
  input logic [NUM_REQ-1:0][CH_FIELD_W-1:0] map_ch
);
  AST_ASSERT_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_assert_evt & ~ch_level) == '0); // R3
  AST_ASSERT_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_assert_evt) |=> ((ch_assert_evt & $past(ch_assert_evt)) == '0)); // R4
  AST_EOR_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_eor_evt) |-> (($past(ch_level) & ch_eor_evt) == ch_eor_evt)); // R5
  AST_EOR_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_eor_evt & ch_level) == '0); // R5
  AST_BAD_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> cfg_err); // R8
  AST_BAD_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(map_vld) && $stable(map_ch))); // R8
endmodule

bind dma_req_router rt_checker #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_level(ch_level), .ch_assert_evt(ch_assert_evt),
  .ch_eor_evt(ch_eor_evt), .cfg_err(cfg_err), .wr_bad(wr_bad),
  .map_vld(map_vld), .map_ch(map_ch)
);

// File: tb/tb_dma_req_router.sv
module tb_dma_req_router;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] req_in = '0;
  logic          bus_wr = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cfg_err;
  logic [NC-1:0] ch_level, ch_assert_evt, ch_eor_evt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_req_router #(.NUM_REQ(NR), .NUM_CH(NC)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_err(cfg_err), .ch_level(ch_level), .ch_assert_evt(ch_assert_evt),
    .ch_eor_evt(ch_eor_evt)
  );

  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] ra;
    logic [31:0] exp;
    logic        exp_err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 8'h83, 16'h0100, 32'h83, 1'b0}, // R1 req0 -> ch3
    '{16'h0104, 8'h8F, 16'h0104, 32'h8F, 1'b0}, // R8 top channel accepted
    '{16'h01FC, 8'h85, 16'h01FC, 32'h85, 1'b0}, // R2 last low register
    '{16'h1100, 8'h81, 16'h1100, 32'h81, 1'b0}, // R2 first high register
    '{16'h1128, 8'h82, 16'h1128, 32'h82, 1'b0}, // R2 last high register
    '{16'h0108, 8'h90, 16'h0108, 32'h00, 1'b1}, // R8 channel 16 refused
    '{16'h010C, 8'h10, 16'h010C, 32'h10, 1'b0}, // R8 disabled entry stored
    '{16'h0110, 8'hE4, 16'h0110, 32'h84, 1'b0}, // R1 reserved bits dropped
    '{16'h112C, 8'h81, 16'h112C, 32'h00, 1'b0}, // R2 past high window
    '{16'h0102, 8'h86, 16'h0100, 32'h83, 1'b0}, // R2 unaligned write ignored
    '{16'h0200, 8'h81, 16'h1104, 32'h00, 1'b0}  // R2 gap address ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {24'hFFFF_FF, d};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
    // R9 reset state
    bus_read(16'h0100, rd); chk("R9 map0 after reset", rd, 32'h0);
    bus_read(16'h1128, rd); chk("R9 map74 after reset", rd, 32'h0);
    chk("R9 levels", 32'(ch_level), 32'h0);
    chk("R9 events", 32'({ch_assert_evt, ch_eor_evt}), 32'h0);
    chk("R9 cfg_err", 32'(cfg_err), 32'h0);

    // table walk: write, check error flag, read back
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].wa, VECS[i].wd);
      chk($sformatf("R8 err vec%0d", i), 32'(cfg_err), 32'(VECS[i].exp_err));
      bus_read(VECS[i].ra, rd);
      chk($sformatf("R1/R2 read vec%0d", i), rd, VECS[i].exp);
    end
    step;
    chk("R8 err one cycle", 32'(cfg_err), 32'h0);

    // second request onto channel 3
    bus_write(16'h0108, 8'h83);
    step;

    // R3 rising edge of req0 -> ch3
    req_in[0] = 1'b1; step;
    chk("R3 assert evt", 32'(ch_assert_evt), 32'h8);
    chk("R3 level", 32'(ch_level), 32'h8);
    chk("R5 no eor on rise", 32'(ch_eor_evt), 32'h0);
    step;
    chk("R4 no repeat", 32'(ch_assert_evt), 32'h0);
    chk("R4 level held", 32'(ch_level), 32'h8);
    step;
    chk("R4 still quiet", 32'(ch_assert_evt), 32'h0);

    // R7 overlap on one channel
    req_in[2] = 1'b1; step;
    chk("R7 no second assert", 32'(ch_assert_evt), 32'h0);
    req_in[0] = 1'b0; step;
    chk("R7 no early eor", 32'(ch_eor_evt), 32'h0);
    chk("R7 level OR", 32'(ch_level), 32'h8);
    req_in[2] = 1'b0; step;
    chk("R5 eor evt", 32'(ch_eor_evt), 32'h8);
    chk("R5 level low", 32'(ch_level), 32'h0);
    step;
    chk("R5 eor one cycle", 32'(ch_eor_evt), 32'h0);

    // R6 disabled request (req3, enable clear)
    req_in[3] = 1'b1; step;
    chk("R6 no level", 32'(ch_level), 32'h0);
    chk("R6 no assert", 32'(ch_assert_evt), 32'h0);
    req_in[3] = 1'b0; step;
    chk("R6 no eor", 32'(ch_eor_evt), 32'h0);

    // R2 high window request 74 -> ch2
    req_in[74] = 1'b1; step;
    chk("R2 high window assert", 32'(ch_assert_evt), 32'h4);
    req_in[74] = 1'b0; step;
    chk("R2 high window eor", 32'(ch_eor_evt), 32'h4);

    // R3 top channel via req1 -> ch15
    req_in[1] = 1'b1; step;
    chk("R3 top channel", 32'(ch_assert_evt), 32'h8000);
    req_in[1] = 1'b0; step;
    step;

    // R9 reset clears maps again
    rst_n = 1'b0; step; rst_n = 1'b1; step;
    bus_read(16'h0100, rd); chk("R9 map cleared", rd, 32'h0);
    bus_read(16'h1100, rd); chk("R9 high map cleared", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule